// File: doc/BRIEF.md
# Base Address Window Decoder

This block holds the six 32-bit base address registers of one device function and uses them to claim incoming transactions. Each register is fixed at build time as unused, a 32-bit memory window, the low half of a 64-bit memory window, or an I/O window, and each window has a fixed power-of-two size. Configuration software writes a register and reads it back through a simple dword-wide port. The low bits of the readback report the window kind and cannot be written. The bits below the window size are fixed at zero, so writing all ones and reading back shows the size.

Each request carries a 64-bit address and a flag that marks it as I/O space or memory space. The block compares the request address with every programmed window. One clock later it reports a hit, the index of the claiming register and the byte offset into the device register bank. Memory windows and I/O windows can point at the same register bank, so a driver can reach the device either way. Two enable inputs gate memory-space and I/O-space decoding on their own.

Top module: `barwin_top`

## Requirements
- R1: The registers sit at dword-aligned configuration byte offsets 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24, in index order 0 to 5. Every other offset reads 0, and so does any offset whose bits 1:0 are not zero. A write to such an offset changes nothing. After reset every writable bit is 0.
- R2: An unused register always reads 0x00000000, and writes to it are ignored.
- R3: A memory register reads bit 0 as 0. It reads bits 2:1 as 00 for a 32-bit window and 10 for a 64-bit window. It reads bit 3 as its build-time prefetchable flag. Writes cannot change these bits.
- R4: An I/O register reads bit 0 as 1 and bit 1 as 0. Writes cannot change these bits.
- R5: In a window of 2^S bytes, bits S-1:0 read as type bits or zero whatever is written, and bits 31:S keep the written value.
- R6: The register that follows a 64-bit memory register holds address bits 63:32. All 32 of its bits are writable and read back as written.
- R7: A memory request hits a 32-bit memory window when address bits 63:32 are zero and bits 31:S equal the programmed base. The result appears on the outputs one clock after the request.
- R8: An I/O request hits an I/O window when address bits 63:32 are zero and bits 31:S equal the programmed base. I/O requests never hit memory windows, and memory requests never hit I/O windows.
- R9: A 64-bit memory window hits when address bits 63:32 equal the following register and bits 31:S equal the base. The following register is never reported as a hit on its own.
- R10: With memEnable low no memory request hits. With ioEnable low no I/O request hits.
- R11: On a hit, hitOffset carries address bits S-1:0 with zeros above. On a miss, hit, hitIdx and hitOffset are all 0.
- R12: When more than one window matches, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Combinational readback at cfgAddr |
| memEnable | input | 1 | Memory-space decode enable |
| ioEnable | input | 1 | I/O-space decode enable |
| reqValid | input | 1 | Request present this cycle |
| reqIsIo | input | 1 | 1 for an I/O-space request, 0 for memory space |
| reqAddr | input | 64 | Request address |
| hit | output | 1 | Registered: previous request was claimed |
| hitIdx | output | 3 | Registered: index of the claiming register |
| hitOffset | output | 32 | Registered: offset into the register bank |

## Verification
The bench uses the default build. Register 0 is a 128 KiB 32-bit memory window and register 1 is unused. Register 2 is a 32-byte I/O window. Registers 3 and 4 form a prefetchable 1 MiB 64-bit pair, and register 5 is a 4 KiB 32-bit memory window. This mix puts every register kind, the upper half of a 64-bit pair and an unused slot in one build. The small window can be placed inside the large one, which exercises lowest-index priority. The I/O window and the memory windows can map the same low addresses, which shows that I/O and memory requests are kept apart.

// File: rtl/barwin_pkg.sv
package barwin_pkg;

  typedef enum logic [1:0] {
    BAR_UNUSED = 2'd0,
    BAR_MEM32  = 2'd1,
    BAR_MEM64  = 2'd2,
    BAR_IO     = 2'd3
  } barKind_e;

  localparam int IDX_W = 3;
  localparam logic [7:0] FIRST_BAR_OFS = 8'h10;

  // strobes handed from control to datapath
  typedef struct packed {
    logic             cfgHit;
    logic             wrStb;
    logic [IDX_W-1:0] barSel;
    logic             memLook;
    logic             ioLook;
  } barStrobes_t;

endpackage

// File: rtl/barwin_ctrl.sv
module barwin_ctrl
  import barwin_pkg::*;
#(
  parameter int NUM_BARS = 6
) (
  input  logic        [7:0] cfgAddr,
  input  logic              cfgWrEn,
  input  logic              reqValid,
  input  logic              reqIsIo,
  input  logic              memEnable,
  input  logic              ioEnable,
  output barStrobes_t       strb
);

  localparam logic [5:0] FIRST_DW = FIRST_BAR_OFS[7:2];
  localparam logic [5:0] LAST_DW  = 6'(int'(FIRST_DW) + NUM_BARS - 1);

  logic [5:0] dwIdx;
  logic [5:0] relIdx;

  always_comb begin
    dwIdx        = cfgAddr[7:2];
    relIdx       = dwIdx - FIRST_DW;
    strb.cfgHit  = (cfgAddr[1:0] == 2'b00) && (dwIdx >= FIRST_DW) && (dwIdx <= LAST_DW);
    strb.barSel  = relIdx[IDX_W-1:0];
    strb.wrStb   = strb.cfgHit && cfgWrEn;
    strb.memLook = reqValid && !reqIsIo && memEnable;
    strb.ioLook  = reqValid && reqIsIo && ioEnable;
  end

endmodule

// File: rtl/barwin_dp.sv
module barwin_dp
  import barwin_pkg::*;
#(
  parameter int                        NUM_BARS      = 6,
  parameter logic [NUM_BARS-1:0][1:0]  BAR_KIND      = {BAR_MEM32, BAR_UNUSED, BAR_MEM64,
                                                        BAR_IO, BAR_UNUSED, BAR_MEM32},
  parameter logic [NUM_BARS-1:0][4:0]  BAR_SIZE_LOG2 = {5'd12, 5'd0, 5'd20, 5'd5, 5'd0, 5'd17},
  parameter logic [NUM_BARS-1:0]       BAR_PREFETCH  = 6'b001000
) (
  input  logic              clk,
  input  logic              rstN,
  input  barStrobes_t       strb,
  input  logic       [31:0] cfgWrData,
  input  logic       [63:0] reqAddr,
  output logic       [31:0] cfgRdData,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic       [31:0] hitOffset
);

  logic [31:0]         baseQ  [NUM_BARS];
  logic [31:0]         rdBack [NUM_BARS];
  logic [31:0]         offs   [NUM_BARS];
  logic [NUM_BARS-1:0] hitVec;
  logic                upperZero;

  assign upperZero = (reqAddr[63:32] == 32'd0);

  for (genvar gi = 0; gi < NUM_BARS; gi++) begin : g_bar
    localparam logic [1:0]  KIND      = BAR_KIND[gi];
    localparam bit          IS_UPPER  = (gi > 0) &&
                                        (BAR_KIND[(gi > 0) ? gi - 1 : 0] == BAR_MEM64);
    localparam logic [31:0] SIZE_MASK = (32'd1 << BAR_SIZE_LOG2[gi]) - 32'd1;
    localparam logic [31:0] WR_MASK   = IS_UPPER ? 32'hFFFF_FFFF :
                                        (KIND == BAR_UNUSED) ? 32'd0 : ~SIZE_MASK;
    localparam logic [31:0] TYPE_BITS =
        IS_UPPER            ? 32'd0 :
        (KIND == BAR_IO)    ? 32'd1 :
        (KIND == BAR_MEM64) ? {28'd0, BAR_PREFETCH[gi], 3'b100} :
        (KIND == BAR_MEM32) ? {28'd0, BAR_PREFETCH[gi], 3'b000} : 32'd0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[gi] <= 32'd0;
      end else if (strb.wrStb && strb.barSel == IDX_W'(gi)) begin
        baseQ[gi] <= cfgWrData & WR_MASK;
      end
    end

    assign rdBack[gi] = baseQ[gi] | TYPE_BITS;
    assign offs[gi]   = reqAddr[31:0] & SIZE_MASK;

    if (IS_UPPER || KIND == BAR_UNUSED) begin : g_none
      assign hitVec[gi] = 1'b0;
    end else if (KIND == BAR_IO) begin : g_io
      assign hitVec[gi] = strb.ioLook && upperZero &&
                          ((reqAddr[31:0] & ~SIZE_MASK) == baseQ[gi]);
    end else if (KIND == BAR_MEM32) begin : g_m32
      assign hitVec[gi] = strb.memLook && upperZero &&
                          ((reqAddr[31:0] & ~SIZE_MASK) == baseQ[gi]);
    end else if (gi < NUM_BARS - 1) begin : g_m64
      assign hitVec[gi] = strb.memLook && (reqAddr[63:32] == baseQ[gi+1]) &&
                          ((reqAddr[31:0] & ~SIZE_MASK) == baseQ[gi]);
    end else begin : g_m64_bad
      assign hitVec[gi] = 1'b0;
    end
  end

  assign cfgRdData = strb.cfgHit ? rdBack[strb.barSel] : 32'd0;

  logic             selHit;
  logic [IDX_W-1:0] selIdx;
  logic [31:0]      selOff;

  always_comb begin
    selHit = 1'b0;
    selIdx = '0;
    selOff = 32'd0;
    for (int i = NUM_BARS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selHit = 1'b1;
        selIdx = IDX_W'(i);
        selOff = offs[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit       <= 1'b0;
      hitIdx    <= '0;
      hitOffset <= 32'd0;
    end else begin
      hit       <= selHit;
      hitIdx    <= selIdx;
      hitOffset <= selOff;
    end
  end

endmodule

// File: rtl/barwin_top.sv
module barwin_top
  import barwin_pkg::*;
#(
  parameter int                        NUM_BARS      = 6,
  parameter logic [NUM_BARS-1:0][1:0]  BAR_KIND      = {BAR_MEM32, BAR_UNUSED, BAR_MEM64,
                                                        BAR_IO, BAR_UNUSED, BAR_MEM32},
  parameter logic [NUM_BARS-1:0][4:0]  BAR_SIZE_LOG2 = {5'd12, 5'd0, 5'd20, 5'd5, 5'd0, 5'd17},
  parameter logic [NUM_BARS-1:0]       BAR_PREFETCH  = 6'b001000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  cfgAddr,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        memEnable,
  input  logic        ioEnable,
  input  logic        reqValid,
  input  logic        reqIsIo,
  input  logic [63:0] reqAddr,
  output logic        hit,
  output logic [2:0]  hitIdx,
  output logic [31:0] hitOffset
);

  barStrobes_t strb;

  barwin_ctrl #(.NUM_BARS(NUM_BARS)) ctrl_i (
    .cfgAddr  (cfgAddr),
    .cfgWrEn  (cfgWrEn),
    .reqValid (reqValid),
    .reqIsIo  (reqIsIo),
    .memEnable(memEnable),
    .ioEnable (ioEnable),
    .strb     (strb)
  );

  barwin_dp #(
    .NUM_BARS     (NUM_BARS),
    .BAR_KIND     (BAR_KIND),
    .BAR_SIZE_LOG2(BAR_SIZE_LOG2),
    .BAR_PREFETCH (BAR_PREFETCH)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgWrData(cfgWrData),
    .reqAddr  (reqAddr),
    .cfgRdData(cfgRdData),
    .hit      (hit),
    .hitIdx   (hitIdx),
    .hitOffset(hitOffset)
  );

endmodule

// File: rtl/barwin_chk.sv
module barwin_chk
  import barwin_pkg::*;
#(
  parameter int                        NUM_BARS      = 6,
  parameter logic [NUM_BARS-1:0][1:0]  BAR_KIND      = {BAR_MEM32, BAR_UNUSED, BAR_MEM64,
                                                        BAR_IO, BAR_UNUSED, BAR_MEM32},
  parameter logic [NUM_BARS-1:0][4:0]  BAR_SIZE_LOG2 = {5'd12, 5'd0, 5'd20, 5'd5, 5'd0, 5'd17}
) (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  cfgAddr,
  input logic [31:0] cfgRdData,
  input logic        memEnable,
  input logic        ioEnable,
  input logic        reqValid,
  input logic        reqIsIo,
  input logic        hit,
  input logic [2:0]  hitIdx,
  input logic [31:0] hitOffset
);

  logic [4:0] selSize;
  logic       selDecodable;
  logic       rdIsIo;
  logic       rdIsMem;
  logic       rdIsUnused;

  always_comb begin
    selSize      = 5'd0;
    selDecodable = 1'b0;
    if (int'(hitIdx) < NUM_BARS) begin
      selSize      = BAR_SIZE_LOG2[hitIdx];
      selDecodable = (BAR_KIND[hitIdx] != BAR_UNUSED) &&
                     !(hitIdx != 3'd0 && BAR_KIND[hitIdx - 3'd1] == BAR_MEM64);
    end
    rdIsIo     = 1'b0;
    rdIsMem    = 1'b0;
    rdIsUnused = 1'b0;
    if (cfgAddr[1:0] == 2'b00 && cfgAddr >= FIRST_BAR_OFS &&
        int'(cfgAddr[7:2]) < int'(FIRST_BAR_OFS[7:2]) + NUM_BARS) begin
      for (int i = 0; i < NUM_BARS; i++) begin
        if (int'(cfgAddr[7:2]) == int'(FIRST_BAR_OFS[7:2]) + i) begin
          rdIsIo     = (BAR_KIND[i] == BAR_IO);
          rdIsMem    = (BAR_KIND[i] == BAR_MEM32) || (BAR_KIND[i] == BAR_MEM64);
          rdIsUnused = (BAR_KIND[i] == BAR_UNUSED) &&
                       !(i > 0 && BAR_KIND[(i > 0) ? i - 1 : 0] == BAR_MEM64);
        end
      end
    end
  end

  p_hit_follows_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> $past(reqValid));

  p_io_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hit && $past(reqIsIo)) |-> $past(ioEnable));

  p_mem_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !$past(reqIsIo)) |-> $past(memEnable));

  p_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (hitIdx == 3'd0 && hitOffset == 32'd0));

  p_offset_fits_r11: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> ((hitOffset >> selSize) == 32'd0));

  p_decodable_idx_r9: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> selDecodable);

  p_io_low_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdIsIo |-> (cfgRdData[1:0] == 2'b01));

  p_mem_bit0_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdIsMem |-> (cfgRdData[0] == 1'b0));

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdIsUnused |-> (cfgRdData == 32'd0));

endmodule

bind barwin_top barwin_chk #(
  .NUM_BARS     (NUM_BARS),
  .BAR_KIND     (BAR_KIND),
  .BAR_SIZE_LOG2(BAR_SIZE_LOG2)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cfgAddr  (cfgAddr),
  .cfgRdData(cfgRdData),
  .memEnable(memEnable),
  .ioEnable (ioEnable),
  .reqValid (reqValid),
  .reqIsIo  (reqIsIo),
  .hit      (hit),
  .hitIdx   (hitIdx),
  .hitOffset(hitOffset)
);

// File: tb/barwin_top_tb_top.sv
module barwin_top_tb_top;
  import barwin_pkg::*;

  localparam int NB = 6;
  localparam logic [NB-1:0][1:0] TB_KIND = {BAR_MEM32, BAR_UNUSED, BAR_MEM64,
                                            BAR_IO, BAR_UNUSED, BAR_MEM32};
  localparam logic [NB-1:0][4:0] TB_SIZE = {5'd12, 5'd0, 5'd20, 5'd5, 5'd0, 5'd17};
  localparam logic [NB-1:0]      TB_PF   = 6'b001000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  cfgAddr;
  logic        cfgWrEn;
  logic [31:0] cfgWrData;
  logic [31:0] cfgRdData;
  logic        memEnable;
  logic        ioEnable;
  logic        reqValid;
  logic        reqIsIo;
  logic [63:0] reqAddr;
  logic        hit;
  logic [2:0]  hitIdx;
  logic [31:0] hitOffset;

  barwin_top #(
    .NUM_BARS(NB), .BAR_KIND(TB_KIND), .BAR_SIZE_LOG2(TB_SIZE), .BAR_PREFETCH(TB_PF)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .memEnable(memEnable), .ioEnable(ioEnable), .reqValid(reqValid),
    .reqIsIo(reqIsIo), .reqAddr(reqAddr), .hit(hit), .hitIdx(hitIdx), .hitOffset(hitOffset)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] model [NB];

  function automatic bit isUpper(int i);
    return (i > 0) && (TB_KIND[(i > 0) ? i - 1 : 0] == BAR_MEM64);
  endfunction

  function automatic logic [31:0] sizeMask(int i);
    return (32'd1 << TB_SIZE[i]) - 32'd1;
  endfunction

  function automatic logic [31:0] wrMask(int i);
    if (isUpper(i)) return 32'hFFFF_FFFF;
    if (TB_KIND[i] == BAR_UNUSED) return 32'd0;
    return ~sizeMask(i);
  endfunction

  function automatic logic [31:0] typeBits(int i);
    if (isUpper(i)) return 32'd0;
    case (TB_KIND[i])
      BAR_IO:    return 32'h1;
      BAR_MEM32: return TB_PF[i] ? 32'h8 : 32'h0;
      BAR_MEM64: return TB_PF[i] ? 32'hC : 32'h4;
      default:   return 32'd0;
    endcase
  endfunction

  function automatic int offToIdx(logic [7:0] a);
    if (a[1:0] != 2'b00 || a < 8'h10 || a > 8'h24) return -1;
    return int'((a - 8'h10) >> 2);
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    int i = offToIdx(a);
    if (i < 0) return 32'd0;
    return model[i] | typeBits(i);
  endfunction

  function automatic bit winMatch(int i, logic io, logic [63:0] adr);
    logic loOk;
    if (isUpper(i) || TB_KIND[i] == BAR_UNUSED) return 1'b0;
    loOk = ((adr[31:0] & ~sizeMask(i)) == model[i]);
    case (TB_KIND[i])
      BAR_IO:    return io && ioEnable && adr[63:32] == 32'd0 && loOk;
      BAR_MEM32: return !io && memEnable && adr[63:32] == 32'd0 && loOk;
      BAR_MEM64: return (i < NB - 1) && !io && memEnable &&
                        adr[63:32] == model[(i < NB - 1) ? i + 1 : i] && loOk;
      default:   return 1'b0;
    endcase
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWr(logic [7:0] a, logic [31:0] d);
    int i = offToIdx(a);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (i >= 0) model[i] = d & wrMask(i);
  endtask

  task automatic cfgRd(logic [7:0] a, string req);
    @(negedge clk);
    cfgAddr = a;
    #1;
    check(req, $sformatf("read 0x%0h", a), {32'd0, cfgRdData}, {32'd0, expRead(a)});
  endtask

  task automatic look(logic io, logic [63:0] adr, string req);
    logic eh; logic [2:0] ei; logic [31:0] eo;
    @(negedge clk);
    reqValid = 1'b1; reqIsIo = io; reqAddr = adr;
    eh = 1'b0; ei = 3'd0; eo = 32'd0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (winMatch(i, io, adr)) begin
        eh = 1'b1; ei = 3'(i); eo = adr[31:0] & sizeMask(i);
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    check(req, $sformatf("hit io=%0d a=0x%0h", io, adr), {63'd0, hit}, {63'd0, eh});
    check(req, "hitIdx", {61'd0, hitIdx}, {61'd0, ei});
    check(req, "hitOffset", {32'd0, hitOffset}, {32'd0, eo});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R7 watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) model[i] = 32'd0;
    rstN = 1'b0; cfgAddr = 8'd0; cfgWrEn = 1'b0; cfgWrData = 32'd0;
    memEnable = 1'b0; ioEnable = 1'b0; reqValid = 1'b0; reqIsIo = 1'b0; reqAddr = 64'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "reset hit", {63'd0, hit}, 64'd0);

    // reset values and type bits
    cfgRd(8'h10, "R3"); cfgRd(8'h14, "R2"); cfgRd(8'h18, "R4");
    cfgRd(8'h1C, "R3"); cfgRd(8'h20, "R6"); cfgRd(8'h24, "R3");
    cfgRd(8'h0C, "R1"); cfgRd(8'h28, "R1"); cfgRd(8'h12, "R1");

    // sizing by writing all ones
    for (int i = 0; i < NB; i++) cfgWr(8'(8'h10 + 4 * i), 32'hFFFF_FFFF);
    cfgRd(8'h10, "R5"); cfgRd(8'h14, "R2"); cfgRd(8'h18, "R5");
    cfgRd(8'h1C, "R5"); cfgRd(8'h20, "R6"); cfgRd(8'h24, "R5");
    check("R5", "bar0 size readback", {32'd0, expRead(8'h10)}, 64'hFFFE_0000);
    check("R3", "bar3 size readback", {32'd0, expRead(8'h1C)}, 64'hFFF0_000C);

    // misaligned write is ignored
    cfgWr(8'h10, 32'd0);
    cfgWr(8'h13, 32'hFFFF_FFFF);
    cfgRd(8'h10, "R1");

    // program windows
    cfgWr(8'h10, 32'hE820_0000);
    cfgWr(8'h14, 32'h1234_5678);
    cfgRd(8'h14, "R2");
    cfgWr(8'h18, 32'h0000_5001);
    cfgWr(8'h1C, 32'h4000_000C);
    cfgWr(8'h20, 32'h0000_0001);
    cfgWr(8'h24, 32'hE820_1000);
    cfgRd(8'h18, "R4"); cfgRd(8'h20, "R6");
    memEnable = 1'b1; ioEnable = 1'b1;

    look(1'b0, 64'h0000_0000_E820_0010, "R7");
    look(1'b0, 64'h0000_0000_E821_FFFC, "R11");
    look(1'b0, 64'h0000_0000_E820_1004, "R12");
    look(1'b0, 64'h0000_0000_E822_0000, "R7");
    look(1'b0, 64'h0000_0001_E820_0010, "R7");
    look(1'b1, 64'h0000_0000_0000_5007, "R8");
    look(1'b1, 64'h0000_0000_0000_5020, "R8");
    look(1'b1, 64'h0000_0000_E820_0010, "R8");
    look(1'b0, 64'h0000_0000_0000_5007, "R8");
    look(1'b0, 64'h0000_0001_4000_0123, "R9");
    look(1'b0, 64'h0000_0000_4000_0123, "R9");
    look(1'b0, 64'h0000_0001_400F_FFFF, "R9");
    memEnable = 1'b0;
    look(1'b0, 64'h0000_0000_E820_0010, "R10");
    look(1'b1, 64'h0000_0000_0000_5003, "R10");
    ioEnable = 1'b0; memEnable = 1'b1;
    look(1'b1, 64'h0000_0000_0000_5003, "R10");
    look(1'b0, 64'h0000_0001_4000_0040, "R10");
    ioEnable = 1'b1;

    // constrained random mix
    void'($urandom(32'h0000_5EED));
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom % 10);
      if (r < 2) begin
        int j = int'($urandom % NB);
        cfgWr(8'(8'h10 + 4 * j), $urandom);
      end else if (r < 8) begin
        int j = int'($urandom % NB);
        logic [63:0] adr;
        logic io;
        if ($urandom % 4 == 0) begin
          adr = {(($urandom % 2) == 0) ? 32'd0 : $urandom, $urandom};
          io  = 1'($urandom);
        end else begin
          adr[31:0]  = model[j] | ($urandom & sizeMask(j));
          adr[63:32] = (TB_KIND[j] == BAR_MEM64 && j < NB - 1) ? model[(j < NB - 1) ? j + 1 : j] : 32'd0;
          io = (TB_KIND[j] == BAR_IO) ^ ($urandom % 8 == 0);
        end
        if ($urandom % 16 == 0) memEnable = ~memEnable;
        if ($urandom % 16 == 0) ioEnable = ~ioEnable;
        look(io, adr, "R7 R8 R9 R10 R11 R12");
      end else begin
        cfgRd(8'(8'h0C + ($urandom % 8) * 4), "R1 R3 R4 R5 R6");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule